// File: doc/BRIEF.md
# Wait-State Bus Cycle Sequencer

This block is the master side of a multiplexed 16-bit bus. The requesting core issues a one-cycle request pulse while the sequencer is idle. The sequencer then takes the access through four kinds of phase, one clock each: an address phase (T1), a strobe-launch phase (T2), one or more access phases (T3) and a closing phase (T4). It drives the read strobe, the write strobe, a timing-state flag and the data-buffer enable. On reads it captures the data from the shared address/data lines. When the access closes it gives the core a single-cycle completion pulse together with the captured word.

Slow devices stretch an access by making the sequencer repeat T3. At the clock edge that ends T2, the sequencer reads two active-low, binary-weighted wait inputs that preload a count of zero to three extra T3 phases. It also reads an active-low continuous-wait input. Once the preloaded waits are used up, the continuous-wait input is read again at the end of every inserted wait, and each active reading adds one more T3. A request can be marked non-extendable. Such a cycle always has exactly one T3, whatever the wait inputs do.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is asserted and after it is released with no request, `busy_o`, `done_o`, `tso_o`, `rd_o`, `wr_o`, `dbe_o` and `ad_oe_o` are all low.
- R2: A high `req_i` in an idle cycle starts an access. The next cycle is T1: `ad_o` carries the latched address, `ad_oe_o` is high, and all four strobes are low. T1 lasts one cycle and is followed by T2.
- R3: `tso_o`, `dbe_o` and the direction strobe (`rd_o` for a read, `wr_o` for a write) rise together at the start of T2. They hold constant through every T3 of the cycle.
- R4: `wait_n_i` is active low, with bit 1 weighted 2 and bit 0 weighted 1. The values 11, 10, 01 and 00 preload 0, 1, 2 and 3 extra T3 phases after the first one.
- R5: `wait_n_i` matters only at the clock edge that ends T2. Its value at any other edge does not change the cycle length.
- R6: `cwait_n_i` (active low) is read at the end of T2. If the preload is zero and the input is active, one extra T3 is added. After the last preloaded or added wait, the input is read again at the end of each wait phase, and each active reading adds one more T3. An inactive reading moves the cycle to T4.
- R7: When `req_noext_i` is high with the request, the cycle has exactly one T3 phase regardless of `wait_n_i` and `cwait_n_i`.
- R8: At the start of T4, `tso_o`, `rd_o` and `wr_o` go low. `dbe_o` stays high until the falling clock edge inside T4 and is low from then on.
- R9: On a read, `ad_i` is captured at the clock edge that ends the last T3. `done_o` is high for exactly the T4 cycle, and `rdata_o` holds the captured word from T4 until the next read captures a new one. A write leaves `rdata_o` unchanged.
- R10: On a write, `ad_o` carries the latched write data and `ad_oe_o` is high from T2 through T4. On a read, `ad_oe_o` is low from T2 through T4.
- R11: `req_i` and the request attributes are ignored while `busy_o` is high, and the cycle after T4 is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one T phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | 1 | Request pulse, accepted only while idle |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| req_noext_i | input | 1 | 1 = cycle may not be stretched |
| req_addr_i | input | 16 | Address placed on the bus in T1 |
| req_wdata_i | input | 16 | Write data driven in T2 to T4 |
| wait_n_i | input | 2 | Binary-weighted wait request, active low, bit 1 weight 2 |
| cwait_n_i | input | 1 | Continuous wait request, active low |
| ad_i | input | 16 | Address/data lines as seen by the master |
| ad_o | output | 16 | Value driven onto the address/data lines |
| ad_oe_o | output | 1 | Output enable for `ad_o` |
| tso_o | output | 1 | Timing-state flag, high in T2 and T3 |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |
| dbe_o | output | 1 | Data-buffer enable, active high |
| busy_o | output | 1 | High from T1 through T4 |
| done_o | output | 1 | One-cycle completion pulse in T4 |
| rdata_o | output | 16 | Last captured read word |

## Verification
The bench varies the lines on every cycle and drives a different word on `ad_i` in each T3. A design that samples the wait inputs at a different edge ends its T4 at a different cycle, and one that captures the read word one edge off returns the word from the wrong T3. Four corner cases get their own stimulus. The first is a zero preload with an active continuous wait, where a design that skips the first resample ends one wait too early. The second is a nonzero preload followed by continuous waits, where a design that counts both at once adds too few waits. The third is a non-extendable cycle with every wait input active, where a wrong design stretches it. The fourth is the buffer enable, which must fall only at the falling edge in T4; a design that drops it together with the strobes fails the early-T4 sample.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    BS_IDLE = 3'd0,
    BS_T1   = 3'd1,
    BS_T2   = 3'd2,
    BS_T3   = 3'd3,
    BS_T4   = 3'd4
  } bus_phase_e;

endpackage

// File: rtl/bcs_wait_ctrl.sv
module bcs_wait_ctrl #(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              at_t2,
  input  logic              at_t3,
  input  logic              extend_en,
  input  logic [WAIT_W-1:0] wait_n,
  input  logic              cwait_n,
  output logic              stretch
);

  localparam int CNT_W = WAIT_W;

  logic [CNT_W-1:0] wcnt_q, wcnt_d, preset;
  logic             cwpend_q, cwpend_d;
  logic             inwait_q, inwait_d;

  // active-low binary weighted preload, forced to zero for fixed-length cycles
  assign preset = extend_en ? CNT_W'(~wait_n) : '0;

  assign stretch = at_t3 && ((wcnt_q != '0) || cwpend_q ||
                             (inwait_q && extend_en && !cwait_n));

  always_comb begin
    wcnt_d   = wcnt_q;
    cwpend_d = cwpend_q;
    inwait_d = inwait_q;
    if (at_t2) begin
      wcnt_d   = preset;
      cwpend_d = extend_en && !cwait_n && (preset == '0);
      inwait_d = 1'b0;
    end else if (at_t3) begin
      if (wcnt_q != '0) wcnt_d = wcnt_q - CNT_W'(1);
      cwpend_d = 1'b0;
      inwait_d = stretch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q   <= '0;
      cwpend_q <= 1'b0;
      inwait_q <= 1'b0;
    end else if (at_t2 || at_t3) begin
      wcnt_q   <= wcnt_d;
      cwpend_q <= cwpend_d;
      inwait_q <= inwait_d;
    end
  end

  // R4: a pending preload is consumed one wait at a time
  p_wcnt_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (at_t3 && wcnt_q != '0) |=> (at_t3 && wcnt_q == $past(wcnt_q) - CNT_W'(1)));

  // R6: an active continuous-wait reading after a wait keeps the cycle in T3
  p_cwait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_t3 && inwait_q && extend_en && wcnt_q == '0 && !cwait_n) |=> at_t3);

  // R7: a fixed-length cycle leaves its single T3 without stretching
  p_noext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (at_t2 && !extend_en) |=> (at_t3 && !stretch));

endmodule

// File: rtl/bcs_strobe_gen.sv
module bcs_strobe_gen
  import bcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bus_phase_e phase,
  input  logic       is_write,
  output logic       tso,
  output logic       rd,
  output logic       wr,
  output logic       dbe
);

  logic active;
  logic dbe_off_q;

  assign active = (phase == BS_T2) || (phase == BS_T3);
  assign tso    = active;
  assign rd     = active && !is_write;
  assign wr     = active && is_write;

  // set on the falling edge inside T4 to end the buffer enable half a cycle late
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) dbe_off_q <= 1'b0;
    else        dbe_off_q <= (phase == BS_T4);
  end

  assign dbe = active || ((phase == BS_T4) && !dbe_off_q);

  // R3: control outputs are flat across repeated T3 phases
  p_flat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == BS_T3 && $past(phase) == BS_T3) |-> $stable({tso, rd, wr, dbe}));

  // R8: strobes and timing flag are off throughout T4
  p_t4_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == BS_T4) |-> (!tso && !rd && !wr));

endmodule

// File: rtl/bcs_data_path.sv
module bcs_data_path
  import bcs_pkg::*;
#(
  parameter int AD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  bus_phase_e      phase,
  input  logic            is_write,
  input  logic            capture,
  input  logic [AD_W-1:0] addr,
  input  logic [AD_W-1:0] wdata,
  input  logic [AD_W-1:0] ad_i,
  output logic [AD_W-1:0] ad_o,
  output logic            ad_oe,
  output logic [AD_W-1:0] rdata
);

  logic [AD_W-1:0] rdata_q;
  logic            cap_en;
  logic            data_phase;

  assign data_phase = (phase == BS_T2) || (phase == BS_T3) || (phase == BS_T4);
  assign ad_o  = (phase == BS_T1) ? addr : wdata;
  assign ad_oe = (phase == BS_T1) || (data_phase && is_write);

  assign cap_en = capture && !is_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= ad_i;
  end

  assign rdata = rdata_q;

  // R9: the read word only changes on the edge that closes a read
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(rdata_q));

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int AD_W   = 16,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              req_write_i,
  input  logic              req_noext_i,
  input  logic [AD_W-1:0]   req_addr_i,
  input  logic [AD_W-1:0]   req_wdata_i,
  input  logic [WAIT_W-1:0] wait_n_i,
  input  logic              cwait_n_i,
  input  logic [AD_W-1:0]   ad_i,
  output logic [AD_W-1:0]   ad_o,
  output logic              ad_oe_o,
  output logic              tso_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              dbe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [AD_W-1:0]   rdata_o
);

  bus_phase_e      phase_q, phase_d;
  logic            accept;
  logic            stretch;
  logic            write_q, noext_q;
  logic [AD_W-1:0] addr_q, wdata_q;

  assign accept = (phase_q == BS_IDLE) && req_i;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      BS_IDLE: if (req_i) phase_d = BS_T1;
      BS_T1:   phase_d = BS_T2;
      BS_T2:   phase_d = BS_T3;
      BS_T3:   phase_d = stretch ? BS_T3 : BS_T4;
      BS_T4:   phase_d = BS_IDLE;
      default: phase_d = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= BS_IDLE;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      noext_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      write_q <= req_write_i;
      noext_q <= req_noext_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  bcs_wait_ctrl #(.WAIT_W(WAIT_W)) u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .at_t2     (phase_q == BS_T2),
    .at_t3     (phase_q == BS_T3),
    .extend_en (!noext_q),
    .wait_n    (wait_n_i),
    .cwait_n   (cwait_n_i),
    .stretch   (stretch)
  );

  bcs_strobe_gen u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase_q),
    .is_write (write_q),
    .tso      (tso_o),
    .rd       (rd_o),
    .wr       (wr_o),
    .dbe      (dbe_o)
  );

  bcs_data_path #(.AD_W(AD_W)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase_q),
    .is_write (write_q),
    .capture  ((phase_q == BS_T3) && !stretch),
    .addr     (addr_q),
    .wdata    (wdata_q),
    .ad_i     (ad_i),
    .ad_o     (ad_o),
    .ad_oe    (ad_oe_o),
    .rdata    (rdata_o)
  );

  assign busy_o = (phase_q != BS_IDLE);
  assign done_o = (phase_q == BS_T4);

  // R2: an idle request opens T1, and T1 always hands over to T2
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == BS_IDLE && req_i) |=> (phase_q == BS_T1));
  p_t1_t2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == BS_T1) |=> (phase_q == BS_T2));

  // R11: requests during an access neither restart it nor alter its attributes
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(addr_q) && $stable(write_q) && phase_q != BS_T1));

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: tb/test_bus_cycle_seq.sv
module test_bus_cycle_seq;

  localparam int AD_W   = 16;
  localparam int WAIT_W = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_i, req_write_i, req_noext_i;
  logic [AD_W-1:0]   req_addr_i, req_wdata_i, ad_i;
  logic [WAIT_W-1:0] wait_n_i;
  logic              cwait_n_i;
  logic [AD_W-1:0]   ad_o, rdata_o;
  logic              ad_oe_o, tso_o, rd_o, wr_o, dbe_o, busy_o, done_o;

  int              n_chk = 0;
  int              n_bad = 0;
  logic [AD_W-1:0] last_rd = '0;

  always #2 clk = ~clk;   // 250 MHz

  bus_cycle_seq #(.AD_W(AD_W), .WAIT_W(WAIT_W)) i_bus_cycle_seq (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_write_i(req_write_i),
    .req_noext_i(req_noext_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .wait_n_i(wait_n_i), .cwait_n_i(cwait_n_i), .ad_i(ad_i), .ad_o(ad_o),
    .ad_oe_o(ad_oe_o), .tso_o(tso_o), .rd_o(rd_o), .wr_o(wr_o), .dbe_o(dbe_o),
    .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // number of T3 phases from the wait rules (R4, R6, R7)
  function automatic int exp_t3(input bit noext, input logic [1:0] wn, input logic [15:0] cw);
    int p;
    int n;
    if (noext) return 1;
    p = 3 - int'(wn);
    n = 1 + p;
    if (p == 0 && cw[0]) n++;
    if (n > 1)
      while (cw[n] && n < 14) n++;
    return n;
  endfunction

  task automatic run(input bit wr, input bit noext, input logic [1:0] wn,
                     input logic [15:0] cw, input logic [15:0] addr,
                     input logic [15:0] data, input string rq);
    int n;
    n = exp_t3(noext, wn, cw);
    @(posedge clk); #3;
    req_i = 1'b1; req_write_i = wr; req_noext_i = noext;
    req_addr_i = addr; req_wdata_i = data;
    wait_n_i = 2'($urandom); cwait_n_i = 1'($urandom); ad_i = 16'($urandom);
    for (int k = 1; k <= 3 + n; k++) begin
      @(posedge clk); #1;
      if (k == 1) begin
        chk("R2 T1 strobes", {tso_o, rd_o, wr_o, dbe_o}, 4'b0000);
        chk("R2 T1 address", {ad_oe_o, ad_o}, {1'b1, addr});
        chk("R11 T1 busy", busy_o, 1'b1);
      end else if (k <= 2 + n) begin
        chk({rq, " R3 T2/T3 strobes"}, {tso_o, rd_o, wr_o, dbe_o, done_o},
            {1'b1, !wr, wr, 1'b1, 1'b0});
        if (wr) chk("R10 write data", {ad_oe_o, ad_o}, {1'b1, data});
        else    chk("R10 read no drive", ad_oe_o, 1'b0);
      end else begin
        chk({rq, " R8 T4 early"}, {tso_o, rd_o, wr_o, dbe_o}, 4'b0001);
        chk({rq, " R9 done"}, done_o, 1'b1);
        if (wr) begin
          chk("R9 write keeps rdata", rdata_o, last_rd);
          chk("R10 T4 write data", {ad_oe_o, ad_o}, {1'b1, data});
        end else begin
          chk({rq, " R9 captured word"}, rdata_o, data ^ 16'(n));
        end
      end
      #2;
      if (k == 3 + n) chk("R8 dbe after falling edge", dbe_o, 1'b0);
      req_i       = (k < 3 + n) ? 1'($urandom) : 1'b0;
      req_write_i = 1'($urandom);
      req_noext_i = 1'($urandom);
      req_addr_i  = 16'($urandom);
      req_wdata_i = 16'($urandom);
      wait_n_i    = (k == 2) ? wn : 2'($urandom);   // R5 noise elsewhere
      if (k == 2)                       cwait_n_i = !cw[0];
      else if (k >= 3 && k <= 2 + n)    cwait_n_i = !cw[k-2];
      else                              cwait_n_i = 1'($urandom);
      ad_i = (k >= 3 && k <= 2 + n) ? (data ^ 16'(k - 2)) : 16'($urandom);
    end
    if (!wr) last_rd = data ^ 16'(n);
    @(posedge clk); #1;
    chk("R11 idle after T4", {busy_o, done_o, tso_o, dbe_o}, 4'b0000);
    chk("R9 rdata held", rdata_o, last_rd);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_i = 1'b0; req_write_i = 1'b0; req_noext_i = 1'b0;
    req_addr_i = '0; req_wdata_i = '0; wait_n_i = '1; cwait_n_i = 1'b1; ad_i = '0;
    #9;
    chk("R1 in reset", {busy_o, done_o, tso_o, rd_o, wr_o, dbe_o, ad_oe_o}, 7'd0);
    @(posedge clk); #3; rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 after reset", {busy_o, done_o, tso_o, rd_o, wr_o, dbe_o, ad_oe_o}, 7'd0);

    run(0, 0, 2'b11, 16'h0000, 16'h1000, 16'hA5A0, "R4 zero");
    run(0, 0, 2'b10, 16'h0000, 16'h1002, 16'h5A50, "R4 one");
    run(0, 0, 2'b01, 16'h0000, 16'h1004, 16'h3C30, "R4 two");
    run(0, 0, 2'b00, 16'h0000, 16'h1006, 16'hC3C0, "R4 three");
    run(0, 0, 2'b11, 16'h0007, 16'h2000, 16'h7770, "R6 cwait only");
    run(1, 0, 2'b01, 16'h001C, 16'h2002, 16'h8880, "R6 preset then cwait");
    run(0, 0, 2'b01, 16'h001C, 16'h2004, 16'h9990, "R6 preset then cwait rd");
    run(0, 1, 2'b00, 16'h3FFF, 16'h3000, 16'h4440, "R7 fixed length");
    run(1, 1, 2'b00, 16'h3FFF, 16'h3002, 16'h6660, "R7 fixed length wr");
    run(1, 0, 2'b11, 16'h0000, 16'h4000, 16'hBEE0, "R10 write");

    for (int i = 0; i < 40; i++) begin
      run(1'($urandom), ($urandom % 5) == 0, 2'($urandom),
          16'($urandom & $urandom) & 16'h3FFF,
          16'($urandom), 16'($urandom) & 16'hFFF0, "R5 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule